// File: doc/BRIEF.md
# MDIO Management Master with Host Registers

This block runs single management transactions towards Ethernet PHYs over a two-wire serial management bus. A host programs two 32-bit registers through a simple write port: a data register and a command register. Writing the command register with its start bit set launches one transaction. The block then drives the management clock MDC and a tri-state MDIO line. It sends a full frame, and for reads it captures the value the PHY returns.

Two addressing styles are supported. In the short style (Clause 22), a single frame carries a 5-bit PHY address and a 5-bit register number. In the extended style (Clause 45), the 5-bit register field names the MMD device instead. One start command then produces two frames in a row: an address frame carrying a 16-bit register address from the upper half of the data register, followed by the read or write frame. The MDC rate is a selectable fraction of the host clock. While a transaction runs, the busy bit stays set. Host writes to either register are discarded until busy clears.

Top module: `mdio_master_csr`

## Requirements
- R1: After reset, both registers read 0, MDC is low and MDIO is not driven (mdio_oe = 0).
- R2: Command register layout: bit 0 start/busy, bit 1 extended-style enable, bits 3:2 operation (01 write, 11 read; bit 3 set means read), bits 10:8 clock select, bits 20:16 register/device field, bits 25:21 PHY address. Writing it while idle with bit 0 = 1 starts a transaction. Bit 0 then reads 1 until the transaction ends and reads 0 afterwards. A write with bit 0 = 0 stores the fields and produces no MDC edge. The other bits read back as written.
- R3: A short-style frame is 64 bits sent MSB first: 32 ones, start 01, opcode 01 (write) or 10 (read), 5-bit PHY address, 5-bit register, turnaround 10, then 16 data bits. Write data is data register bits 15:0.
- R4: An extended-style command sends two back-to-back frames. The first has start 00, opcode 00 and carries data register bits 31:16 in its data field. The second has start 00, opcode 01 (write) or 11 (read) and carries data register bits 15:0. Both frames carry the same PHY address and device field.
- R5: In a read frame, the master stops driving MDIO for bit positions 46 to 63 (the turnaround and the data). It samples the 16 data bits on MDC rising edges. When the transaction ends, data register bits 15:0 hold the sampled value and bits 31:16 are unchanged.
- R6: While busy reads 1, host writes to the command register and to the data register are ignored. This includes a write that lands in the cycle the transaction ends.
- R7: Clock-select codes 0 to 5 give an MDC period of 16, 26, 42, 62, 102 and 124 host clocks, with equal high and low halves. Codes 6 and 7 give 124.
- R8: MDC is low and MDIO is undriven whenever no transaction is running, including right after a transaction ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Host clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_wr_en | input | 1 | Register write strobe |
| host_wr_sel | input | 1 | Write target: 0 command, 1 data |
| host_wr_data | input | 32 | Register write value |
| host_rd_sel | input | 1 | Read source: 0 command, 1 data |
| host_rd_data | output | 32 | Selected register contents |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | MDIO value driven by the master |
| mdio_oe | output | 1 | MDIO output enable |
| mdio_i | input | 1 | MDIO line as seen by the master |

## Verification
Two events can fall in the same cycle: a host write to the data register, and the end of a read transaction loading the returned value into that register. To provoke the collision, the bench first writes the command register once in mid-transaction. It then writes random data into the data register on every cycle in which busy still reads 1, so one of those writes lands exactly on the completion edge. The result counts as correct only if the data register afterwards holds the PHY's value in its lower half and the original extended address in its upper half. The command fields must also read back exactly as first written.

// File: rtl/mdio_pkg.sv
package mdio_pkg;
  localparam int HOST_W     = 32;
  localparam int FRAME_LEN  = 64;
  localparam int IDX_W      = $clog2(FRAME_LEN);
  localparam int HALF_W     = 7;
  localparam int TA_FIRST   = 46;
  localparam int DATA_FIRST = 48;
  localparam int WORD_W     = 16;
  localparam int ADR_W      = 5;
  localparam int SEL_W      = 3;

  // command field positions
  localparam int C_START  = 0;
  localparam int C_EXT    = 1;
  localparam int C_OPHI   = 3;
  localparam int C_SEL_LO = 8;
  localparam int C_REG_LO = 16;
  localparam int C_PHY_LO = 21;

  typedef enum logic [1:0] {
    ENG_IDLE = 2'd0,
    ENG_ADDR = 2'd1,
    ENG_XFER = 2'd2
  } eng_state_t;

  function automatic logic [HALF_W-1:0] half_cycles(input logic [SEL_W-1:0] sel);
    logic [HALF_W-1:0] h;
    case (sel)
      3'd0:    h = 7'd8;
      3'd1:    h = 7'd13;
      3'd2:    h = 7'd21;
      3'd3:    h = 7'd31;
      3'd4:    h = 7'd51;
      default: h = 7'd62;
    endcase
    return h;
  endfunction

  function automatic logic [FRAME_LEN-1:0] make_frame(
    input logic [1:0]        st,
    input logic [1:0]        op,
    input logic [ADR_W-1:0]  pa,
    input logic [ADR_W-1:0]  ra,
    input logic [WORD_W-1:0] d
  );
    return {32'hFFFF_FFFF, st, op, pa, ra, 2'b10, d};
  endfunction
endpackage

// File: rtl/mdio_clkgen.sv
module mdio_clkgen
  import mdio_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic [HALF_W-1:0] half,
  output logic              tick
);
  logic [HALF_W-1:0] cnt_q, cnt_d;

  always_comb begin
    tick  = run && (cnt_q == half - 1'b1);
    cnt_d = cnt_q;
    if (!run)      cnt_d = '0;
    else if (tick) cnt_d = '0;
    else           cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  AST_TICK_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> !tick); // R7
endmodule

// File: rtl/mdio_frame_engine.sv
module mdio_frame_engine
  import mdio_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              ext,
  input  logic              rd_op,
  input  logic [ADR_W-1:0]  phy,
  input  logic [ADR_W-1:0]  regad,
  input  logic [WORD_W-1:0] wdata,
  input  logic [WORD_W-1:0] xaddr,
  input  logic              tick,
  input  logic              mdio_i,
  output logic              run,
  output logic              mdc,
  output logic              mdio_o,
  output logic              mdio_oe,
  output logic              done,
  output logic [WORD_W-1:0] rdata
);
  eng_state_t           state_q, state_d;
  logic [FRAME_LEN-1:0] frame_q, frame_d;
  logic [IDX_W-1:0]     idx_q, idx_d;
  logic                 hi_q, hi_d;
  logic                 mdc_q, mdc_d;
  logic                 rdf_q, rdf_d;
  logic [WORD_W-1:0]    sin_q, sin_d;
  logic [FRAME_LEN-1:0] xfer_frame, addr_frame;
  logic                 last_bit;

  always_comb begin
    last_bit   = (idx_q == IDX_W'(FRAME_LEN - 1));
    addr_frame = make_frame(2'b00, 2'b00, phy, regad, xaddr);
    if (ext) xfer_frame = make_frame(2'b00, rd_op ? 2'b11 : 2'b01, phy, regad, wdata);
    else     xfer_frame = make_frame(2'b01, rd_op ? 2'b10 : 2'b01, phy, regad, wdata);

    state_d = state_q;
    frame_d = frame_q;
    idx_d   = idx_q;
    hi_d    = hi_q;
    mdc_d   = mdc_q;
    rdf_d   = rdf_q;
    sin_d   = sin_q;
    done    = 1'b0;

    if (state_q == ENG_IDLE) begin
      if (start) begin
        idx_d = '0;
        hi_d  = 1'b0;
        mdc_d = 1'b0;
        if (ext) begin
          frame_d = addr_frame;
          rdf_d   = 1'b0;
          state_d = ENG_ADDR;
        end else begin
          frame_d = xfer_frame;
          rdf_d   = rd_op;
          state_d = ENG_XFER;
        end
      end
    end else if (tick) begin
      if (!hi_q) begin
        mdc_d = 1'b1;
        hi_d  = 1'b1;
        if (rdf_q && idx_q >= IDX_W'(DATA_FIRST))
          sin_d = {sin_q[WORD_W-2:0], mdio_i};
      end else begin
        mdc_d = 1'b0;
        hi_d  = 1'b0;
        if (last_bit) begin
          if (state_q == ENG_ADDR) begin
            frame_d = xfer_frame;
            rdf_d   = rd_op;
            idx_d   = '0;
            state_d = ENG_XFER;
          end else begin
            state_d = ENG_IDLE;
            done    = 1'b1;
          end
        end else begin
          idx_d   = idx_q + 1'b1;
          frame_d = {frame_q[FRAME_LEN-2:0], 1'b0};
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ENG_IDLE;
      frame_q <= '0;
      idx_q   <= '0;
      hi_q    <= 1'b0;
      mdc_q   <= 1'b0;
      rdf_q   <= 1'b0;
      sin_q   <= '0;
    end else begin
      state_q <= state_d;
      frame_q <= frame_d;
      idx_q   <= idx_d;
      hi_q    <= hi_d;
      mdc_q   <= mdc_d;
      rdf_q   <= rdf_d;
      sin_q   <= sin_d;
    end
  end

  assign run     = (state_q != ENG_IDLE);
  assign mdc     = mdc_q;
  assign mdio_o  = run ? frame_q[FRAME_LEN-1] : 1'b1;
  assign mdio_oe = run && !(rdf_q && idx_q >= IDX_W'(TA_FIRST));
  assign rdata   = sin_q;

  AST_MDC_IDLE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ENG_IDLE) |-> !mdc_q); // R8
  AST_START_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> (state_q == ENG_IDLE)); // R2
endmodule

// File: rtl/mdio_csr.sv
module mdio_csr
  import mdio_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              wr_sel,
  input  logic [HOST_W-1:0] wr_data,
  input  logic              rd_sel,
  input  logic              done,
  input  logic [WORD_W-1:0] rdata,
  output logic [HOST_W-1:0] rd_data,
  output logic              start,
  output logic              ext,
  output logic              rd_op,
  output logic [SEL_W-1:0]  clk_sel,
  output logic [ADR_W-1:0]  phy,
  output logic [ADR_W-1:0]  regad,
  output logic [WORD_W-1:0] wdata,
  output logic [WORD_W-1:0] xaddr
);
  logic [HOST_W-1:1] cmd_q, cmd_d;
  logic [HOST_W-1:0] data_q, data_d;
  logic              busy_q, busy_d;
  logic              start_q, start_d;
  logic              accept;

  always_comb begin
    accept  = wr_en && !busy_q;
    cmd_d   = cmd_q;
    data_d  = data_q;
    busy_d  = busy_q;
    start_d = 1'b0;
    if (accept && !wr_sel) begin
      cmd_d = wr_data[HOST_W-1:1];
      if (wr_data[C_START]) begin
        busy_d  = 1'b1;
        start_d = 1'b1;
      end
    end
    if (accept && wr_sel) data_d = wr_data;
    if (done) begin
      busy_d = 1'b0;
      if (rd_op) data_d[WORD_W-1:0] = rdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_q   <= '0;
      data_q  <= '0;
      busy_q  <= 1'b0;
      start_q <= 1'b0;
    end else begin
      cmd_q   <= cmd_d;
      data_q  <= data_d;
      busy_q  <= busy_d;
      start_q <= start_d;
    end
  end

  assign rd_data = rd_sel ? data_q : {cmd_q, busy_q};
  assign start   = start_q;
  assign ext     = cmd_q[C_EXT];
  assign rd_op   = cmd_q[C_OPHI];
  assign clk_sel = cmd_q[C_SEL_LO +: SEL_W];
  assign regad   = cmd_q[C_REG_LO +: ADR_W];
  assign phy     = cmd_q[C_PHY_LO +: ADR_W];
  assign wdata   = data_q[WORD_W-1:0];
  assign xaddr   = data_q[HOST_W-1:WORD_W];

  AST_CMD_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && $past(busy_q)) |-> $stable(cmd_q)); // R6
  AST_XADDR_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && $past(busy_q)) |-> $stable(data_q[HOST_W-1:WORD_W])); // R6
  AST_DONE_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> busy_q); // R2
endmodule

// File: rtl/mdio_master_csr.sv
module mdio_master_csr
  import mdio_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_wr_en,
  input  logic              host_wr_sel,
  input  logic [HOST_W-1:0] host_wr_data,
  input  logic              host_rd_sel,
  output logic [HOST_W-1:0] host_rd_data,
  output logic              mdc,
  output logic              mdio_o,
  output logic              mdio_oe,
  input  logic              mdio_i
);
  logic              start, ext, rd_op, run, tick, done;
  logic [SEL_W-1:0]  clk_sel;
  logic [ADR_W-1:0]  phy, regad;
  logic [WORD_W-1:0] wdata, xaddr, rdata;

  mdio_csr u_csr (
    .clk(clk), .rst_n(rst_n),
    .wr_en(host_wr_en), .wr_sel(host_wr_sel), .wr_data(host_wr_data),
    .rd_sel(host_rd_sel), .done(done), .rdata(rdata), .rd_data(host_rd_data),
    .start(start), .ext(ext), .rd_op(rd_op), .clk_sel(clk_sel),
    .phy(phy), .regad(regad), .wdata(wdata), .xaddr(xaddr)
  );

  mdio_clkgen u_clk (
    .clk(clk), .rst_n(rst_n), .run(run),
    .half(half_cycles(clk_sel)), .tick(tick)
  );

  mdio_frame_engine u_eng (
    .clk(clk), .rst_n(rst_n), .start(start), .ext(ext), .rd_op(rd_op),
    .phy(phy), .regad(regad), .wdata(wdata), .xaddr(xaddr),
    .tick(tick), .mdio_i(mdio_i), .run(run), .mdc(mdc),
    .mdio_o(mdio_o), .mdio_oe(mdio_oe), .done(done), .rdata(rdata)
  );
endmodule

// File: tb/sim_mdio_master_csr.sv
`timescale 1ns/1ps
module sim_mdio_master_csr;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        host_wr_en, host_wr_sel, host_rd_sel;
  logic [31:0] host_wr_data, host_rd_data;
  logic        mdc, mdio_o, mdio_oe;
  logic        phy_en = 1'b0, phy_bit = 1'b1;
  wire         mdio_line = mdio_oe ? mdio_o : (phy_en ? phy_bit : 1'b1);

  int total = 0, bad = 0, cyc = 0, rise_cnt = 0, phy_base = -1;
  logic [15:0] phy_val = 16'h0;
  logic        bits   [0:127];
  logic        oe_rec [0:127];
  int          rise_t [0:127];

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc++;

  mdio_master_csr u0 (
    .clk(clk), .rst_n(rst_n), .host_wr_en(host_wr_en), .host_wr_sel(host_wr_sel),
    .host_wr_data(host_wr_data), .host_rd_sel(host_rd_sel), .host_rd_data(host_rd_data),
    .mdc(mdc), .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_line)
  );

  always @(posedge mdc) begin
    if (rise_cnt < 128) begin
      bits[rise_cnt]   = mdio_line;
      oe_rec[rise_cnt] = mdio_oe;
      rise_t[rise_cnt] = cyc;
    end
    rise_cnt++;
  end

  // PHY responder: drives TA low bit and data on falling MDC edges
  always @(negedge mdc) begin
    int k;
    k = rise_cnt - phy_base;
    if (phy_base >= 0 && k >= 47 && k <= 63) begin
      phy_en  = 1'b1;
      phy_bit = (k == 47) ? 1'b0 : phy_val[15-(k-48)];
    end else begin
      phy_en  = 1'b0;
      phy_bit = 1'b1;
    end
  end

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [63:0] exp_frame(input logic [1:0] st, input logic [1:0] op,
                                            input logic [4:0] pa, input logic [4:0] ra,
                                            input logic [15:0] d);
    return {{32{1'b1}}, st, op, pa, ra, 2'b10, d};
  endfunction

  function automatic int ratio_of(input logic [2:0] cs);
    case (cs)
      3'd0: return 16;
      3'd1: return 26;
      3'd2: return 42;
      3'd3: return 62;
      3'd4: return 102;
      default: return 124;
    endcase
  endfunction

  task automatic host_write(input logic sel, input logic [31:0] d);
    host_wr_en = 1'b1; host_wr_sel = sel; host_wr_data = d;
    @(negedge clk);
    host_wr_en = 1'b0;
  endtask

  task automatic run_op(input bit ext, input bit rd, input logic [4:0] pa, input logic [4:0] ra,
                        input logic [2:0] cs, input logic [15:0] wd, input logic [15:0] xa,
                        input logic [15:0] rv, input bit disturb);
    logic [31:0] cmdw;
    logic [63:0] ef, act, oev;
    int b;
    host_write(1'b1, {xa, wd});
    rise_cnt = 0;
    phy_val  = rv;
    phy_base = rd ? (ext ? 64 : 0) : -1;
    cmdw = {6'b0, pa, ra, 5'b0, cs, 4'b0, (rd ? 2'b11 : 2'b01), ext, 1'b1};
    host_rd_sel = 1'b0;
    host_write(1'b0, cmdw);
    chk("R2 busy set after start", {63'b0, host_rd_data[0]}, 64'd1);
    if (disturb) begin
      repeat (100) @(negedge clk);
      host_write(1'b0, (~cmdw) | 32'd1);
      while (host_rd_data[0]) begin
        host_wr_en = 1'b1; host_wr_sel = 1'b1; host_wr_data = $urandom;
        @(negedge clk);
      end
      host_wr_en = 1'b0;
    end else begin
      while (host_rd_data[0]) @(negedge clk);
    end
    repeat (2) @(negedge clk);
    chk("R4 MDC rising edge count", rise_cnt, ext ? 128 : 64);
    chk("R8 idle after op", {62'b0, mdc, mdio_oe}, 64'd0);
    chk("R7 MDC period", rise_t[1] - rise_t[0], ratio_of(cs));
    if (ext) begin
      ef = exp_frame(2'b00, 2'b00, pa, ra, xa);
      for (int i = 0; i < 64; i++) begin act[63-i] = bits[i]; oev[63-i] = oe_rec[i]; end
      chk("R4 address frame", act, ef);
      chk("R4 address frame driven", oev, {64{1'b1}});
      ef = exp_frame(2'b00, rd ? 2'b11 : 2'b01, pa, ra, wd);
    end else begin
      ef = exp_frame(2'b01, rd ? 2'b10 : 2'b01, pa, ra, wd);
    end
    b = ext ? 64 : 0;
    for (int i = 0; i < 64; i++) begin act[63-i] = bits[b+i]; oev[63-i] = oe_rec[b+i]; end
    if (rd) begin
      chk("R3 read frame header", act[63:18], ef[63:18]);
      chk("R5 line released TA and data", oev, {{46{1'b1}}, 18'b0});
      chk("R5 bus data seen", act[15:0], rv);
    end else begin
      chk("R3 write frame", act, ef);
      chk("R3 write frame driven", oev, {64{1'b1}});
    end
    host_rd_sel = 1'b1; #1;
    chk(disturb ? "R6 data reg after busy writes" : "R5 data reg after op",
        host_rd_data, {xa, rd ? rv : wd});
    host_rd_sel = 1'b0; #1;
    chk(disturb ? "R6 cmd reg after busy write" : "R2 cmd readback",
        host_rd_data, cmdw & ~32'd1);
    phy_base = -1;
    @(negedge clk);
  endtask

  initial begin
    wait (cyc >= 190000);
    bad++; total++;
    $display("FAIL watchdog actual=%0d expected<190000", cyc);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    rst_n = 1'b0; host_wr_en = 1'b0; host_wr_sel = 1'b0;
    host_wr_data = '0; host_rd_sel = 1'b0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    host_rd_sel = 1'b0; #1;
    chk("R1 cmd reg at reset", host_rd_data, 0);
    host_rd_sel = 1'b1; #1;
    chk("R1 data reg at reset", host_rd_data, 0);
    chk("R1 pins at reset", {62'b0, mdc, mdio_oe}, 0);
    host_rd_sel = 1'b0;
    @(negedge clk);

    // fields without start bit: no activity
    rise_cnt = 0;
    host_write(1'b0, 32'h03FF_070E);
    repeat (60) @(negedge clk);
    chk("R2 no start without bit0", rise_cnt, 0);
    chk("R2 fields stored", host_rd_data, 32'h03FF_070E);

    run_op(0, 0, 5'd31, 5'd31, 3'd5, 16'hA5C3, 16'h0000, 16'h0000, 0);
    run_op(0, 1, 5'd0,  5'd1,  3'd0, 16'h7777, 16'h0000, 16'h1234, 1);
    run_op(1, 0, 5'd5,  5'd3,  3'd1, 16'h0F0F, 16'hBEEF, 16'h0000, 0);
    run_op(1, 1, 5'd17, 5'd30, 3'd4, 16'h5555, 16'h0001, 16'h8001, 1);
    run_op(0, 1, 5'd9,  5'd0,  3'd7, 16'h0000, 16'hC0DE, 16'hFFFF, 0);

    for (int n = 0; n < 10; n++) begin
      run_op($urandom % 2, $urandom % 2, 5'($urandom), 5'($urandom), 3'($urandom % 3),
             16'($urandom), 16'($urandom), 16'($urandom), ($urandom % 3) == 0);
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule